// File: doc/BRIEF.md
# Byte-Wide Strobed Configuration Loader

This block sits on the host side of an FPGA configuration link. It pulls a bitstream from a valid/ready byte stream and hands each byte to the target over an 8-bit data bus with an active-low write strobe. After each byte, the target pulls its ready line low while it digests the byte. The time it stays low depends on process, voltage and temperature, roughly 0.4 to 1.6 us. The loader therefore waits for the line to go low and come back high before it presents the next byte. It never relies on a fixed rate.

A load begins with a start pulse. The loader pulses the target's configuration-reset line low, then waits for the target's status line to rise. After that it streams bytes. A bitstream ends in all-ones padding, so the target can raise its done line before the stream is exhausted. A mode input, sampled at start, chooses what happens next. In stop mode the loader finishes as soon as done is seen and releases the data pins. In drain mode it keeps sending until the stream's last byte, which suits targets whose shared data pins are inputs after configuration. Three conditions end the load with an error and a cause code: the status line falling mid-load, a handshake that takes too long, and a stream that ends without done.

Top module: `pp_cfg_loader`

## Requirements
- R1: After reset the configuration-reset line and the write strobe are high, the data-bus enable is low, the stream is not accepted (s_ready_o low), and both load_ok_o and load_err_o are low.
- R2: A start pulse drives cfg_reset_n_o low for exactly RST_CYC clock cycles (default 8). Bytes are requested only after the status input is seen high.
- R3: The byte is on cfg_data_o with cfg_data_oe_o high for at least one cycle before the write strobe falls. It stays unchanged for at least one cycle after the strobe rises.
- R4: The write strobe stays low for at least STROBE_CYC cycles (default 4) per byte.
- R5: After each strobe, the next strobe is not issued until the ready input has been seen low and then high again. Bytes reach the target in stream order, each exactly once.
- R6: In stop mode (drain_mode_i = 0 at start), a handshake that completes with done high ends the load. load_ok_o goes high, cfg_data_oe_o goes low, and no further stream bytes are accepted.
- R7: In drain mode (drain_mode_i = 1 at start), the loader keeps sending bytes after done until the byte marked s_last_i. load_ok_o then rises if done is high.
- R8: If the byte marked s_last_i completes its handshake while done is low, load_err_o rises with err_cause_o = 2'b11.
- R9: If the status input is low at any point during byte transfer, the load aborts. load_err_o rises with err_cause_o = 2'b01, the strobe stays high and the data-bus enable drops.
- R10: If the ready input has not returned high BUSY_TO cycles after the strobe is released (default 1000, i.e. 4 us at 250 MHz), load_err_o rises with err_cause_o = 2'b10. This happens exactly BUSY_TO+1 cycles after the strobe rise.
- R11: A start pulse during a load is ignored. A start pulse after a finished or failed load clears the flags and begins a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a load (one-cycle pulse) |
| drain_mode_i | input | 1 | 1 = send the whole stream, 0 = stop at done; sampled at start |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | DATA_W | Stream byte |
| s_last_i | input | 1 | Marks the final byte of the stream |
| s_ready_o | output | 1 | Loader accepts the stream byte this cycle |
| cfg_data_o | output | DATA_W | Data bus to the target |
| cfg_data_oe_o | output | 1 | Data bus drive enable (low = high impedance) |
| wr_strobe_n_o | output | 1 | Active-low write strobe |
| cfg_reset_n_o | output | 1 | Active-low configuration reset to the target |
| tgt_ready_i | input | 1 | Target ready (high) / busy (low), asynchronous |
| tgt_done_i | input | 1 | Target configuration done, asynchronous |
| tgt_status_ok_i | input | 1 | Target status, low = error or in reset, asynchronous |
| load_ok_o | output | 1 | Load finished with done seen |
| load_err_o | output | 1 | Load ended in error |
| err_cause_o | output | 2 | 00 none, 01 status low, 10 busy timeout, 11 no done at end |

## Verification
The bench models a target whose busy time is drawn at random for every byte. It checks that no strobe falls while the modelled target is still busy, which a loader that paced by a fixed count or missed the low phase would violate. In stop mode the stream keeps offering padding after done, so a loader that kept reading or kept driving the pins is caught. In drain mode the padding must all arrive. A hung handshake is timed to the exact cycle of the error, which exposes an off-by-one or a timer restarted at the low phase. A status drop mid-byte must stop all further strobes, and a short stream must end in the no-done error rather than in success.

// File: rtl/cfgld_pkg.sv
// Shared types for the configuration loader.
// Assumes: nothing beyond IEEE 1800-2017.
package cfgld_pkg;

    // Loader sequencing states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RESET,
        ST_WAIT_OK,
        ST_FETCH,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_BUSY_LO,
        ST_BUSY_HI,
        ST_DONE,
        ST_ERROR
    } ld_state_t;

    // Error cause reported on the top-level port.
    typedef enum logic [1:0] {
        ERR_NONE    = 2'b00,
        ERR_STATUS  = 2'b01,
        ERR_TIMEOUT = 2'b10,
        ERR_NODONE  = 2'b11
    } ld_err_t;

endpackage

// File: rtl/cfgld_sync.sv
// Multi-bit, per-bit independent flop-chain synchronizer for
// asynchronous target status lines.
// Assumes: each bit is a level that may be sampled independently;
// STAGES >= 2.
module cfgld_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the asynchronous level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], async_i[g]};
        end

        assign sync_o[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/cfgld_timer.sv
// Loadable down-counter shared by all timed phases of the loader.
// Assumes: a load takes priority over counting; the counter holds at zero.
module cfgld_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load_i)     cnt_q <= load_val_i;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cfgld_seq.sv
// Load sequencer: reset pulse, status wait, per-byte setup/strobe/hold,
// busy handshake with timeout, done handling by mode, error capture.
// Assumes: target inputs arrive already synchronized; timer zero_o is
// valid the cycle after a load; all outputs leave from flops.
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 10,
    parameter int RST_CYC    = 8,
    parameter int STROBE_CYC = 4,
    parameter int BUSY_TO    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              drain_mode_i,
    input  logic              s_valid_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    input  logic              ready_s,
    input  logic              done_s,
    input  logic              status_s,
    input  logic              tmr_zero_i,
    output logic              tmr_load_o,
    output logic [CNT_W-1:0]  tmr_val_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              strobe_n_o,
    output logic              cfg_reset_n_o,
    output logic              ok_o,
    output logic              err_o,
    output logic [1:0]        cause_o
);

    ld_state_t st_q, st_nxt;
    ld_err_t   cause_q, cause_nxt;
    logic      drain_q;
    logic      last_q;
    logic [DATA_W-1:0] data_q;
    logic      strobe_n_q, oe_q, cfg_n_q, ok_q, err_q;

    // True in the states where bytes are being moved to the target.
    function automatic logic in_load(ld_state_t s);
        return (s == ST_FETCH)  || (s == ST_SETUP)   || (s == ST_STROBE) ||
               (s == ST_HOLD)   || (s == ST_BUSY_LO) || (s == ST_BUSY_HI);
    endfunction

    assign s_ready_o = (st_q == ST_FETCH) && status_s;

    // Next-state, timer control and error-cause selection.
    always_comb begin
        st_nxt     = st_q;
        cause_nxt  = cause_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        case (st_q)
            ST_IDLE, ST_DONE, ST_ERROR: begin
                if (start_i) begin
                    st_nxt     = ST_RESET;
                    cause_nxt  = ERR_NONE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CNT_W'(RST_CYC - 1);
                end
            end
            ST_RESET:   if (tmr_zero_i) st_nxt = ST_WAIT_OK;
            ST_WAIT_OK: if (status_s)   st_nxt = ST_FETCH;
            ST_FETCH:   if (s_valid_i)  st_nxt = ST_SETUP;
            ST_SETUP: begin
                st_nxt     = ST_STROBE;
                tmr_load_o = 1'b1;
                tmr_val_o  = CNT_W'(STROBE_CYC - 1);
            end
            ST_STROBE:  if (tmr_zero_i) st_nxt = ST_HOLD;
            ST_HOLD: begin
                st_nxt     = ST_BUSY_LO;
                tmr_load_o = 1'b1;
                tmr_val_o  = CNT_W'(BUSY_TO - 1);
            end
            ST_BUSY_LO: begin
                if (!ready_s) begin
                    st_nxt = ST_BUSY_HI;
                end else if (tmr_zero_i) begin
                    st_nxt    = ST_ERROR;
                    cause_nxt = ERR_TIMEOUT;
                end
            end
            ST_BUSY_HI: begin
                if (ready_s) begin
                    if (done_s && (!drain_q || last_q)) begin
                        st_nxt = ST_DONE;
                    end else if (last_q) begin
                        st_nxt    = ST_ERROR;
                        cause_nxt = ERR_NODONE;
                    end else begin
                        st_nxt = ST_FETCH;
                    end
                end else if (tmr_zero_i) begin
                    st_nxt    = ST_ERROR;
                    cause_nxt = ERR_TIMEOUT;
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
        // A status drop during transfer overrides every other outcome.
        if (in_load(st_q) && !status_s) begin
            st_nxt    = ST_ERROR;
            cause_nxt = ERR_STATUS;
        end
    end

    // State, mode and byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cause_q <= ERR_NONE;
            drain_q <= 1'b0;
            last_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            st_q    <= st_nxt;
            cause_q <= cause_nxt;
            if (st_nxt == ST_RESET && st_q != ST_RESET) drain_q <= drain_mode_i;
            if (s_ready_o && s_valid_i) begin
                data_q <= s_data_i;
                last_q <= s_last_i;
            end
        end
    end

    // Glitch-free pin and flag outputs decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_n_q <= 1'b1;
            oe_q       <= 1'b0;
            cfg_n_q    <= 1'b1;
            ok_q       <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            strobe_n_q <= (st_nxt != ST_STROBE);
            oe_q       <= in_load(st_nxt);
            cfg_n_q    <= (st_nxt != ST_RESET);
            ok_q       <= (st_nxt == ST_DONE);
            err_q      <= (st_nxt == ST_ERROR);
        end
    end

    assign data_o        = data_q;
    assign data_oe_o     = oe_q;
    assign strobe_n_o    = strobe_n_q;
    assign cfg_reset_n_o = cfg_n_q;
    assign ok_o          = ok_q;
    assign err_o         = err_q;
    assign cause_o       = cause_q;

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] low_cnt_q;

    // Count cycles the strobe has been low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                  low_cnt_q <= '0;
        else if (strobe_n_q)         low_cnt_q <= '0;
        else if (low_cnt_q != '1)    low_cnt_q <= low_cnt_q + 1'b1;
    end

    // R3: byte settled on the bus before the strobe falls
    a_r3_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n_q) |-> ($stable(data_q) && $past(oe_q)));

    // R3: byte held one cycle past the strobe rising
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n_q) |=> ($stable(data_q) && oe_q));

    // R4: minimum strobe width
    a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n_q) |-> (low_cnt_q >= CNT_W'(STROBE_CYC)));

    // R6: success only after done was observed
    a_r6_ok_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok_q) |-> $past(done_s));

    // R9: status drop during transfer aborts with the status cause
    a_r9_status_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (in_load(st_q) && !status_s) |=> (err_q && cause_q == ERR_STATUS && strobe_n_q));

endmodule

// File: rtl/pp_cfg_loader.sv
// Top of the byte-wide strobed configuration loader: synchronizes the
// target lines, shares one interval timer and runs the load sequencer.
// Assumes: target lines are asynchronous to clk; clk at 250 MHz makes
// the default BUSY_TO equal 4 us.
module pp_cfg_loader #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RST_CYC     = 8,
    parameter int STROBE_CYC  = 4,
    parameter int BUSY_TO     = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              drain_mode_i,
    input  logic              s_valid_i,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    output logic [DATA_W-1:0] cfg_data_o,
    output logic              cfg_data_oe_o,
    output logic              wr_strobe_n_o,
    output logic              cfg_reset_n_o,
    input  logic              tgt_ready_i,
    input  logic              tgt_done_i,
    input  logic              tgt_status_ok_i,
    output logic              load_ok_o,
    output logic              load_err_o,
    output logic [1:0]        err_cause_o
);

    localparam int MAX_A = (RST_CYC > STROBE_CYC) ? RST_CYC : STROBE_CYC;
    localparam int MAX_C = (MAX_A > BUSY_TO) ? MAX_A : BUSY_TO;
    localparam int CNT_W = $clog2(MAX_C + 1);

    logic [2:0] line_sync;
    logic       tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    cfgld_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({tgt_status_ok_i, tgt_done_i, tgt_ready_i}),
        .sync_o  (line_sync)
    );

    cfgld_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    cfgld_seq #(
        .DATA_W     (DATA_W),
        .CNT_W      (CNT_W),
        .RST_CYC    (RST_CYC),
        .STROBE_CYC (STROBE_CYC),
        .BUSY_TO    (BUSY_TO)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .drain_mode_i  (drain_mode_i),
        .s_valid_i     (s_valid_i),
        .s_data_i      (s_data_i),
        .s_last_i      (s_last_i),
        .s_ready_o     (s_ready_o),
        .ready_s       (line_sync[0]),
        .done_s        (line_sync[1]),
        .status_s      (line_sync[2]),
        .tmr_zero_i    (tmr_zero),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .data_o        (cfg_data_o),
        .data_oe_o     (cfg_data_oe_o),
        .strobe_n_o    (wr_strobe_n_o),
        .cfg_reset_n_o (cfg_reset_n_o),
        .ok_o          (load_ok_o),
        .err_o         (load_err_o),
        .cause_o       (err_cause_o)
    );

endmodule

// File: tb/tb_pp_cfg_loader.sv
// Self-checking bench: randomized target busy times and stream contents,
// plus directed timeout, status-abort, short-stream and restart cases.
module tb_pp_cfg_loader;

    localparam int DW         = 8;
    localparam int RST_CYC    = 8;
    localparam int STROBE_CYC = 4;
    localparam int BUSY_TO    = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic drain = 1'b0;
    logic s_valid = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic s_last = 1'b0;
    logic s_ready;
    logic [DW-1:0] cfg_data;
    logic cfg_oe, strobe_n, cfg_n;
    logic ready_m = 1'b1, done_m = 1'b0, status_m = 1'b1;
    logic ok, err;
    logic [1:0] cause;

    always #2 clk = ~clk;  // 250 MHz

    pp_cfg_loader #(
        .DATA_W(DW), .SYNC_STAGES(2), .RST_CYC(RST_CYC),
        .STROBE_CYC(STROBE_CYC), .BUSY_TO(BUSY_TO)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .drain_mode_i(drain),
        .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last),
        .s_ready_o(s_ready), .cfg_data_o(cfg_data), .cfg_data_oe_o(cfg_oe),
        .wr_strobe_n_o(strobe_n), .cfg_reset_n_o(cfg_n),
        .tgt_ready_i(ready_m), .tgt_done_i(done_m), .tgt_status_ok_i(status_m),
        .load_ok_o(ok), .load_err_o(err), .err_cause_o(cause)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit c, input string tag, input int act, input int exp);
        checks++;
        if (!c) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---- cycle counter (updated at posedge, read at negedge) ----
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---- target model state ----
    logic [DW-1:0] cap [0:63];
    int cap_cnt = 0;
    int need_n = 1;
    int hang_at = -1;
    int kill_at = -1;
    int busy_ctr = 0;
    int stat_dly = 0;
    int low_len = 0;
    int cfg_low = 0;
    int last_cfg_low = 0;
    int cfg_falls = 0;
    int t_hang = 0;
    bit hold_chk = 0;
    logic prev_strobe = 1'b1, prev_oe = 1'b0, prev_cfg = 1'b1;
    logic [DW-1:0] prev_data = '0;

    // Target model and pin-level monitor, evaluated at each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_cfg && !cfg_n) cfg_falls++;
                if (!cfg_n) cfg_low++;
                if (!prev_cfg && cfg_n) begin last_cfg_low = cfg_low; cfg_low = 0; end
                if (!cfg_n) begin
                    status_m = 1'b0; done_m = 1'b0; ready_m = 1'b1;
                    cap_cnt = 0; stat_dly = 6; hold_chk = 0;
                end else begin
                    if (stat_dly > 0) begin
                        stat_dly--;
                        if (stat_dly == 0) status_m = 1'b1;
                    end
                    if (prev_strobe && !strobe_n) begin
                        // R3 setup and R5 pacing at the strobe fall
                        chk(prev_oe && cfg_oe && (cfg_data == prev_data), "R3 setup", cfg_data, prev_data);
                        chk(ready_m == 1'b1, "R5 strobe while busy", ready_m, 1);
                        low_len = 1;
                    end else if (!strobe_n) begin
                        low_len++;
                    end
                    if (!prev_strobe && strobe_n) begin
                        chk(low_len >= STROBE_CYC, "R4 strobe width", low_len, STROBE_CYC);
                        if (cap_cnt < 64) cap[cap_cnt] = cfg_data;
                        cap_cnt++;
                        hold_chk = 1;
                        ready_m = 1'b0;
                        busy_ctr = 100 + int'($urandom % 301);
                        if (cap_cnt == kill_at) status_m = 1'b0;
                        if (cap_cnt == hang_at) t_hang = cyc;
                    end else if (hold_chk) begin
                        chk(cfg_oe && cfg_data == cap[cap_cnt-1], "R3 hold", cfg_data, cap[cap_cnt-1]);
                        hold_chk = 0;
                    end else if (!ready_m && cap_cnt != hang_at) begin
                        busy_ctr--;
                        if (busy_ctr <= 0) begin
                            ready_m = 1'b1;
                            if (cap_cnt >= need_n) done_m = 1'b1;
                        end
                    end
                end
            end
            prev_strobe = strobe_n;
            prev_oe = cfg_oe;
            prev_data = cfg_data;
            prev_cfg = cfg_n;
        end
    end

    // ---- stream source ----
    logic [DW-1:0] stream [0:63];
    int src_idx = 0;
    int src_len = 0;
    bit fire = 0;

    // Offer stream bytes at falling edges; advance after each handshake.
    initial begin
        forever begin
            @(negedge clk);
            if (fire) src_idx++;
            if (src_idx < src_len) begin
                s_valid = 1'b1;
                s_data  = stream[src_idx];
                s_last  = (src_idx == src_len - 1);
            end else begin
                s_valid = 1'b0;
                s_last  = 1'b0;
            end
            fire = s_valid && s_ready;
        end
    end

    int t_err = 0;

    // Set up stream and model, start a load, wait for it to end.
    task automatic run_load(input int n_real, input int n_pad, input bit drain_m,
                            input int need, input int hang, input int kill, input bit mid_start);
        @(posedge clk); #1;
        for (int i = 0; i < n_real + n_pad; i++)
            stream[i] = (i < n_real) ? DW'($urandom) : {DW{1'b1}};
        src_len = n_real + n_pad;
        src_idx = 0;
        fire = 0;
        need_n = need;
        hang_at = hang;
        kill_at = kill;
        drain = drain_m;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (mid_start) begin
            repeat (600) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        for (int w = 0; w < 40000; w++) begin
            @(negedge clk);
            if (ok || err) begin
                t_err = cyc;
                break;
            end
        end
        chk(ok || err, "completion", 0, 1);
        repeat (20) @(negedge clk);
    endtask

    // Count bytes the target got that differ from the stream.
    function automatic int mismatches(input int n);
        int m = 0;
        for (int i = 0; i < n; i++)
            if (cap[i] != stream[i]) m++;
        return m;
    endfunction

    task automatic expect_ok(input int n_sent, input string tag);
        chk(ok && !err && cause == 2'b00, {tag, " ok flag"}, {ok, err}, 2);
        chk(cap_cnt == n_sent, {tag, " byte count"}, cap_cnt, n_sent);
        chk(src_idx == n_sent, {tag, " consumed"}, src_idx, n_sent);
        chk(mismatches(n_sent) == 0, {tag, " R5 order"}, mismatches(n_sent), 0);
        chk(!cfg_oe && !s_ready && strobe_n, {tag, " idle pins"}, {cfg_oe, s_ready, strobe_n}, 1);
    endtask

    initial begin
        int falls0, nr, np;
        bit dm;
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_n && strobe_n && !cfg_oe && !s_ready && !ok && !err,
            "R1 reset state", {cfg_n, strobe_n, cfg_oe, s_ready, ok, err}, 6'b110000);

        // Stop mode with padding and an ignored mid-load start (R6, R11, R2)
        falls0 = cfg_falls;
        run_load(12, 5, 1'b0, 12, -1, -1, 1'b1);
        expect_ok(12, "R6 stop");
        chk(cfg_falls - falls0 == 1, "R11 start ignored", cfg_falls - falls0, 1);
        chk(last_cfg_low == RST_CYC, "R2 reset width", last_cfg_low, RST_CYC);

        // Drain mode: padding after done must all be sent (R7)
        run_load(10, 4, 1'b1, 10, -1, -1, 1'b0);
        expect_ok(14, "R7 drain");

        // Randomized loads in both modes
        for (int k = 0; k < 4; k++) begin
            nr = 3 + int'($urandom % 12);
            np = int'($urandom % 6);
            dm = 1'($urandom);
            run_load(nr, np, dm, nr, -1, -1, 1'b0);
            expect_ok(dm ? nr + np : nr, dm ? "R7 random" : "R6 random");
        end

        // Stream ends before done (R8)
        run_load(6, 0, 1'b0, 10, -1, -1, 1'b0);
        chk(err && !ok && cause == 2'b11, "R8 no done", cause, 3);
        chk(cap_cnt == 6, "R8 byte count", cap_cnt, 6);

        // Busy never returns: timeout timing (R10)
        run_load(8, 2, 1'b0, 8, 2, -1, 1'b0);
        chk(err && cause == 2'b10, "R10 timeout cause", cause, 2);
        chk(t_err - t_hang == BUSY_TO + 1, "R10 timeout cycle", t_err - t_hang, BUSY_TO + 1);
        chk(cap_cnt == 2, "R10 no further strobes", cap_cnt, 2);

        // Status drops mid-load (R9)
        run_load(8, 2, 1'b1, 8, -1, 3, 1'b0);
        chk(err && cause == 2'b01, "R9 status cause", cause, 1);
        chk(cap_cnt == 3 && strobe_n && !cfg_oe, "R9 abort pins", cap_cnt, 3);

        // Restart after an error clears flags (R11)
        run_load(5, 3, 1'b0, 5, -1, -1, 1'b0);
        expect_ok(5, "R11 restart");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule